// File: doc/BRIEF.md
# I2C Register Port with Commit-on-STOP

This block is an I2C target that sits on a system clock and oversamples the SCL and SDA lines. Each line first passes through a synchronizer and a glitch filter. After that, edge logic finds START, STOP and the clock edges. A serial engine then decodes transactions addressed to a parameterized 7-bit slave address.

A write transaction has three parts:
- the address byte with R/W = 0;
- a pointer byte that selects a register;
- one or more data bytes.

Data bytes go into a shadow copy of the register file. The live registers, which drive the parallel outputs, take all staged values in the same cycle, and only when a STOP ends the transaction. A read transaction (R/W = 1) returns live registers starting at the current pointer. The block never drives SDA high. It only asserts an open-drain pull-down enable.

A low supply-good input acts as an undervoltage lockout. It sends the engine back to idle and forces the shadow and live registers to zero.

Top module: `i2c_regport_top`

## Requirements
- R1: A START is seen when filtered SDA falls while filtered SCL is high, and a STOP when filtered SDA rises while SCL is high. A START, or a repeated START, always restarts address reception.
- R2: A write is the address byte {SLAVE_ADDR, 0}, then a pointer byte, then data bytes, all MSB first. The block pulls SDA low on the ninth clock of each byte. The register index is the pointer modulo NUM_REGS (a power of two). Successive data bytes go to successive indices and wrap from NUM_REGS-1 to 0. Register i appears at regs_o[8*i +: 8].
- R3: The live registers keep their value until a STOP. At that STOP, every byte staged in the transaction appears on regs_o in the same cycle.
- R4: A repeated START does not commit staged bytes. They stay staged until a later STOP, and reads in between return the old live values.
- R5: After the address byte {SLAVE_ADDR, 1} is acknowledged, the block sends live[pointer] MSB first. The pointer advances only when the master acknowledges. A master NACK makes the block release SDA until the next START or STOP.
- R6: An address byte whose upper seven bits differ from SLAVE_ADDR gets no acknowledge. All further bytes get none either, and nothing is stored until the next START.
- R7: While supply_good is low, the engine returns to idle and all shadow and live registers become zero. Bytes staged before the drop are lost.
- R8: A pulse on SDA or SCL shorter than SPIKE_CYC system clocks is ignored. It is seen neither as a data change nor as a START or STOP.
- R9: The block only ever pulls SDA low. It releases SDA (sda_oe_o = 0) whenever it is not acknowledging or sending a 0 bit.
- R10: After reset, regs_o is all zeros and sda_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| supply_good | input | 1 | Low forces lockout: idle and all registers zero |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain pull-down enable for SDA |
| regs_o | output | NUM_REGS*8 | Live register values, register i at bits 8*i+7:8*i |

## Verification
The bench builds the block with NUM_REGS = 4, SPIKE_CYC = 4 and address 0x45. With only four registers, a pointer byte of 0x07 folds onto index 3, and a three-byte burst from there wraps through index 0. With a four-clock spike width, a two-clock SDA pulse injected while SCL is high would be a false STOP if it got through the filter. SCL runs at about 390 kHz against a 50 MHz system clock. A behavioural model of the shadow and live registers is compared with regs_o on every clock. The comparison allows a short window after each STOP or lockout.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_RX,
        S_RX_ACK,
        S_TX,
        S_TX_ACK,
        S_IGNORE
    } bus_state_e;

    // Events derived from the filtered bus lines, one system cycle wide.
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    function automatic logic addr_hit(byte_t b, logic [6:0] own);
        return b[7:1] == own;
    endfunction

endpackage

// File: rtl/i2cp_deglitch.sv
module i2cp_deglitch #(
    parameter int SPIKE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic clean_o
);
    localparam int SYNC_W = 2;

    logic [SYNC_W-1:0]    sync_q;
    logic [SPIKE_CYC-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            hist_q  <= '1;
            clean_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_W-2:0], raw_i};
            hist_q <= {hist_q[SPIKE_CYC-2:0], sync_q[SYNC_W-1]};
            if (&hist_q)
                clean_o <= 1'b1;
            else if (~|hist_q)
                clean_o <= 1'b0;
        end
    end

endmodule

// File: rtl/i2cp_bus_events.sv
module i2cp_bus_events
    import i2cp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev_o.start    = scl_i & scl_q & sda_q & ~sda_i;
        ev_o.stop     = scl_i & scl_q & ~sda_q & sda_i;
        ev_o.scl_rise = scl_i & ~scl_q;
        ev_o.scl_fall = ~scl_i & scl_q;
        ev_o.sda      = sda_i;
    end

endmodule

// File: rtl/i2cp_reg_bank.sv
module i2cp_reg_bank
    import i2cp_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = 2
) (
    input  logic                     clk,
    input  logic                     clear_i,
    input  logic                     wr_en_i,
    input  logic [IDX_W-1:0]         wr_idx_i,
    input  byte_t                    wr_data_i,
    input  logic                     commit_i,
    input  logic [IDX_W-1:0]         rd_idx_i,
    output byte_t                    rd_data_o,
    output logic [NUM_REGS*8-1:0]    live_o
);
    byte_t shadow_q [NUM_REGS];
    byte_t live_q   [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (clear_i) begin
                shadow_q[g] <= '0;
                live_q[g]   <= '0;
            end else begin
                if (wr_en_i && wr_idx_i == IDX_W'(g))
                    shadow_q[g] <= wr_data_i;
                if (commit_i)
                    live_q[g] <= shadow_q[g];
            end
        end
        assign live_o[g*8 +: 8] = live_q[g];
    end

    assign rd_data_o = live_q[rd_idx_i];

endmodule

// File: rtl/i2c_regport_top.sv
module i2c_regport_top
    import i2cp_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h45,
    parameter int         NUM_REGS   = 4,
    parameter int         SPIKE_CYC  = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   supply_good,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    output logic [NUM_REGS*8-1:0]  regs_o
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic       clr;
    logic       scl_f, sda_f;
    bus_ev_t    ev;
    bus_state_e st;
    logic [3:0] bitcnt;
    byte_t      sh;
    logic [IDX_W-1:0] ptr, rd_idx;
    logic       first_byte, pending, rw, mack;
    logic       wr_en, commit;
    byte_t      rd_data;

    assign clr = rst | ~supply_good;

    // Separate filters so each line rejects its own spikes.
    i2cp_deglitch #(.SPIKE_CYC(SPIKE_CYC)) u_flt_scl (
        .clk(clk), .rst(clr), .raw_i(scl_i), .clean_o(scl_f)
    );
    i2cp_deglitch #(.SPIKE_CYC(SPIKE_CYC)) u_flt_sda (
        .clk(clk), .rst(clr), .raw_i(sda_i), .clean_o(sda_f)
    );

    i2cp_bus_events u_ev (
        .clk(clk), .rst(clr), .scl_i(scl_f), .sda_i(sda_f), .ev_o(ev)
    );

    // Data byte complete at the falling edge after its 8th bit.
    assign wr_en  = (st == S_RX) && ev.scl_fall && (bitcnt == 4'd8) && !first_byte;
    assign commit = ev.stop && pending;
    assign rd_idx = (st == S_TX_ACK) ? ptr + IDX_W'(1) : ptr;

    i2cp_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .clear_i(clr),
        .wr_en_i(wr_en), .wr_idx_i(ptr), .wr_data_i(sh),
        .commit_i(commit),
        .rd_idx_i(rd_idx), .rd_data_o(rd_data),
        .live_o(regs_o)
    );

    always_ff @(posedge clk) begin
        if (clr) begin
            st         <= S_IDLE;
            bitcnt     <= '0;
            sh         <= '0;
            ptr        <= '0;
            first_byte <= 1'b0;
            pending    <= 1'b0;
            rw         <= 1'b0;
            mack       <= 1'b0;
            sda_oe_o   <= 1'b0;
        end else if (ev.start) begin
            st         <= S_ADDR;
            bitcnt     <= '0;
            first_byte <= 1'b1;
            sda_oe_o   <= 1'b0;
        end else if (ev.stop) begin
            st       <= S_IDLE;
            pending  <= 1'b0;
            sda_oe_o <= 1'b0;
        end else begin
            unique case (st)
                S_ADDR: begin
                    if (ev.scl_rise) begin
                        sh     <= {sh[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ev.scl_fall && bitcnt == 4'd8) begin
                        bitcnt <= '0;
                        if (addr_hit(sh, SLAVE_ADDR)) begin
                            rw       <= sh[0];
                            sda_oe_o <= 1'b1;
                            st       <= S_ADDR_ACK;
                        end else begin
                            st <= S_IGNORE;
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (ev.scl_fall) begin
                        bitcnt <= '0;
                        if (rw) begin
                            sh       <= rd_data;
                            sda_oe_o <= ~rd_data[7];
                            st       <= S_TX;
                        end else begin
                            sda_oe_o <= 1'b0;
                            st       <= S_RX;
                        end
                    end
                end
                S_RX: begin
                    if (ev.scl_rise) begin
                        sh     <= {sh[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ev.scl_fall && bitcnt == 4'd8) begin
                        sda_oe_o <= 1'b1;
                        st       <= S_RX_ACK;
                        if (first_byte) begin
                            ptr        <= sh[IDX_W-1:0];
                            first_byte <= 1'b0;
                        end else begin
                            ptr     <= ptr + IDX_W'(1);
                            pending <= 1'b1;
                        end
                    end
                end
                S_RX_ACK: begin
                    if (ev.scl_fall) begin
                        sda_oe_o <= 1'b0;
                        bitcnt   <= '0;
                        st       <= S_RX;
                    end
                end
                S_TX: begin
                    if (ev.scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ev.scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_oe_o <= 1'b0;
                            st       <= S_TX_ACK;
                        end else begin
                            sh       <= {sh[6:0], 1'b0};
                            sda_oe_o <= ~sh[6];
                        end
                    end
                end
                S_TX_ACK: begin
                    if (ev.scl_rise) begin
                        mack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (mack) begin
                            ptr      <= ptr + IDX_W'(1);
                            sh       <= rd_data;
                            sda_oe_o <= ~rd_data[7];
                            bitcnt   <= '0;
                            st       <= S_TX;
                        end else begin
                            st <= S_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: live outputs move only on a STOP commit or a lockout clear.
    a_r3_live_hold: assert property (@(posedge clk) disable iff (rst)
        (supply_good && !ev.stop) |=> $stable(regs_o));

    // R7: lockout empties every register by the next cycle.
    a_r7_lockout_zero: assert property (@(posedge clk) disable iff (rst)
        !supply_good |=> (regs_o == '0));

    // R9: the pull-down is only on while acknowledging or sending data.
    a_r9_oe_only_when_owned: assert property (@(posedge clk) disable iff (rst)
        sda_oe_o |-> (st inside {S_ADDR_ACK, S_RX_ACK, S_TX}));

    // R1: a START always restarts address reception.
    a_r1_start_restarts: assert property (@(posedge clk) disable iff (rst)
        (ev.start && supply_good) |=> (st == S_ADDR));

    // R6: a foreign address byte is never acknowledged.
    a_r6_no_ack_foreign: assert property (@(posedge clk) disable iff (rst)
        (supply_good && st == S_ADDR && ev.scl_fall && bitcnt == 4'd8
         && !addr_hit(sh, SLAVE_ADDR)) |=> (!sda_oe_o && st == S_IGNORE));

endmodule

// File: tb/i2c_regport_top_tb.sv
module i2c_regport_top_tb_top;

    localparam int         NREG  = 4;
    localparam int         SPK   = 4;
    localparam logic [6:0] SADDR = 7'h45;
    localparam int         Q     = 32;

    logic clk = 1'b0;
    logic rst, supply_good, scl_m, sda_m;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    wire  sda_bus = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_regport_top #(.SLAVE_ADDR(SADDR), .NUM_REGS(NREG), .SPIKE_CYC(SPK)) dut_i (
        .clk(clk), .rst(rst), .supply_good(supply_good),
        .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .regs_o(regs)
    );

    logic [7:0] m_live [NREG];
    logic [7:0] m_shadow [NREG];
    logic [NREG*8-1:0] m_prev;
    int checks = 0, errors = 0, settle = 0;
    bit done = 0;

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = m_live[i];
        return f;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // R3 per-clock comparison of live outputs against the model.
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (!(regs == model_flat() || (settle > 0 && regs == m_prev))) begin
                errors++;
                $display("FAIL R3 per-clock regs actual=0x%0h expected=0x%0h", regs, model_flat());
            end
            if (settle > 0) settle--;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_commit();
        m_prev = model_flat();
        for (int i = 0; i < NREG; i++) m_live[i] = m_shadow[i];
        settle = 16;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1;
        model_commit();
        tick(2*Q);
    endtask

    task automatic put_bit(bit b, bit glitch);
        sda_m = b; tick(Q);
        scl_m = 1'b1;
        if (glitch) begin
            tick(8); sda_m = 1'b1; tick(2); sda_m = b; tick(2*Q-10);
        end else begin
            tick(2*Q);
        end
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(logic [7:0] b, int gbit, output bit ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i], i == gbit);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = !sda_bus;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(bit do_ack, output logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(Q);
            d = {d[6:0], sda_bus};
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        put_bit(!do_ack, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] d;
        for (int i = 0; i < NREG; i++) begin m_live[i] = '0; m_shadow[i] = '0; end
        m_prev = '0;
        rst = 1'b1; supply_good = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
        tick(6);
        rst = 1'b0;
        tick(2);
        check(regs == '0, "R10", "regs after reset", int'(regs), 0);
        check(sda_oe == 1'b0, "R10", "sda_oe after reset", sda_oe, 0);

        // Single write to index 1.
        bus_start();
        send_byte({SADDR, 1'b0}, -1, ack);
        check(ack, "R1", "address ack after START", ack, 1);
        send_byte(8'h01, -1, ack);
        check(ack, "R2", "pointer ack", ack, 1);
        send_byte(8'h3C, -1, ack);
        m_shadow[1] = 8'h3C;
        check(ack, "R2", "data ack", ack, 1);
        tick(4);
        check(regs[15:8] == 8'h00, "R3", "reg1 before STOP", regs[15:8], 0);
        bus_stop();
        check(regs[15:8] == 8'h3C, "R3", "reg1 after STOP", regs[15:8], 8'h3C);
        check(sda_oe == 1'b0, "R9", "released when idle", sda_oe, 0);

        // Pointer 0x07 folds to 3; burst wraps 3 -> 0 -> 1.
        bus_start();
        send_byte({SADDR, 1'b0}, -1, ack);
        send_byte(8'h07, -1, ack);
        send_byte(8'h11, -1, ack); m_shadow[3] = 8'h11;
        send_byte(8'h22, -1, ack); m_shadow[0] = 8'h22;
        send_byte(8'h33, -1, ack); m_shadow[1] = 8'h33;
        check(ack, "R2", "third burst byte ack", ack, 1);
        check(regs == {8'h00, 8'h00, 8'h3C, 8'h00}, "R3", "regs held during burst",
              int'(regs), int'({8'h00, 8'h00, 8'h3C, 8'h00}));
        bus_stop();
        check(regs == {8'h11, 8'h00, 8'h33, 8'h22}, "R2", "wrapped burst committed",
              int'(regs), int'({8'h11, 8'h00, 8'h33, 8'h22}));

        // Read from pointer 3 with two ACKs then a NACK.
        bus_start();
        send_byte({SADDR, 1'b0}, -1, ack);
        send_byte(8'h03, -1, ack);
        bus_start();
        send_byte({SADDR, 1'b1}, -1, ack);
        check(ack, "R5", "read address ack", ack, 1);
        recv_byte(1'b1, d);
        check(d == m_live[3], "R5", "read byte idx3", d, m_live[3]);
        recv_byte(1'b1, d);
        check(d == m_live[0], "R5", "read byte idx0", d, m_live[0]);
        recv_byte(1'b0, d);
        check(d == m_live[1], "R5", "read byte idx1", d, m_live[1]);
        tick(Q);
        check(sda_oe == 1'b0, "R5", "released after NACK", sda_oe, 0);
        bus_stop();

        // Foreign address.
        bus_start();
        send_byte({7'h12, 1'b0}, -1, ack);
        check(!ack, "R6", "foreign address not acked", ack, 0);
        send_byte(8'h02, -1, ack);
        check(!ack, "R6", "byte after foreign address", ack, 0);
        send_byte(8'h99, -1, ack);
        bus_stop();
        check(regs[23:16] == 8'h00, "R6", "reg2 untouched", regs[23:16], 0);

        // Repeated START keeps staged data out of live registers.
        bus_start();
        send_byte({SADDR, 1'b0}, -1, ack);
        send_byte(8'h02, -1, ack);
        send_byte(8'hA5, -1, ack); m_shadow[2] = 8'hA5;
        bus_start();
        send_byte({SADDR, 1'b0}, -1, ack);
        send_byte(8'h02, -1, ack);
        bus_start();
        send_byte({SADDR, 1'b1}, -1, ack);
        recv_byte(1'b0, d);
        check(d == 8'h00, "R4", "read before commit returns old", d, 0);
        check(regs[23:16] == 8'h00, "R4", "reg2 not committed at Sr", regs[23:16], 0);
        bus_stop();
        check(regs[23:16] == 8'hA5, "R4", "reg2 committed at STOP", regs[23:16], 8'hA5);

        // Short SDA spike while SCL high must not end the transfer.
        bus_start();
        send_byte({SADDR, 1'b0}, -1, ack);
        send_byte(8'h00, -1, ack);
        send_byte(8'h5A, 2, ack); m_shadow[0] = 8'h5A;
        check(ack, "R8", "ack after spiked byte", ack, 1);
        bus_stop();
        check(regs[7:0] == 8'h5A, "R8", "spiked byte stored", regs[7:0], 8'h5A);

        // Lockout mid-transaction.
        bus_start();
        send_byte({SADDR, 1'b0}, -1, ack);
        send_byte(8'h01, -1, ack);
        send_byte(8'h77, -1, ack);
        supply_good = 1'b0;
        m_prev = model_flat();
        for (int i = 0; i < NREG; i++) begin m_live[i] = '0; m_shadow[i] = '0; end
        settle = 4;
        tick(3);
        check(regs == '0, "R7", "lockout clears regs", int'(regs), 0);
        supply_good = 1'b1;
        tick(2);
        bus_stop();
        check(regs == '0, "R7", "staged byte lost", int'(regs), 0);

        bus_start();
        send_byte({SADDR, 1'b0}, -1, ack);
        check(ack, "R7", "address ack after lockout", ack, 1);
        send_byte(8'h02, -1, ack);
        send_byte(8'h42, -1, ack); m_shadow[2] = 8'h42;
        bus_stop();
        check(regs[23:16] == 8'h42, "R7", "write works after lockout", regs[23:16], 8'h42);

        tick(20);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule